// File: doc/BRIEF.md
# Transactional-Read Synchronous FIFO

This is a single-clock first-in first-out buffer whose read side works as a transaction. Each word the reader acknowledges with `got` moves a speculative read pointer forward. The storage behind that pointer stays reserved. When the reader later pulses `commit`, every acknowledged word is released to the writer. When it pulses `rollback` instead, the speculative pointer returns to the last committed position, and the same words are offered again in the same order.

Because reserved words still count against capacity, the writer can see `full` while the reader sees no `valid` word. Two quantised level outputs give coarse views of the state:

- one reports how many words can be read, as a lower bound;
- the other reports how many more writes are certain to fit, also as a lower bound.

Each level output is built combinationally from a pointer difference. Setting its width parameter to zero ties it to zero. The requested depth is rounded up to a power of two.

Top module: `spec_rd_fifo`

## Requirements
- R1: The capacity is `MIN_DEPTH` rounded up to the next power of two (8 for the default of 5). Exactly that many words are accepted from reset before `full` rises.
- R2: Data leave in the order they were written. `dout` shows the word at the speculative read position whenever `valid` is high, and it stays unchanged until that word is acknowledged or rolled back.
- R3: `valid` is high exactly when unacknowledged words exist. A `got` while `valid` is low has no effect.
- R4: A `put` while `full` is high has no effect: the word is not stored and the state is unchanged.
- R5: Acknowledged but uncommitted words keep occupying storage, so `full` can be high together with `valid` low.
- R6: `commit` releases every word acknowledged since the last commit or rollback, including a `got` in the same cycle. The freed space is visible on `full` and `free_lvl` in the next cycle.
- R7: `rollback` rewinds the reader to the oldest uncommitted word, including one acknowledged in the same cycle. Those words are then presented again in order.
- R8: `fill_lvl` equals floor(readable × 2^FILL_W / depth), saturated at 2^FILL_W−1. Here "readable" is the count of unacknowledged words. With 2 bits, the value counts quarters.
- R9: `free_lvl` equals floor(room × 2^FREE_W / depth), saturated at 2^FREE_W−1. Here "room" is the depth minus the stored words, whether committed or not.
- R10: Synchronous reset empties the FIFO: `full`=0, `valid`=0, `fill_lvl`=0, and `free_lvl` is at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| put | input | 1 | Write request |
| din | input | DATA_W | Write data |
| full | output | 1 | No room for another write |
| free_lvl | output | max(1,FREE_W) | Quantised free-space lower bound |
| got | input | 1 | Read acknowledge (speculative) |
| dout | output | DATA_W | Word at the speculative read position |
| valid | output | 1 | `dout` holds an unacknowledged word |
| fill_lvl | output | max(1,FILL_W) | Quantised readable-word lower bound |
| commit | input | 1 | Release all acknowledged words |
| rollback | input | 1 | Re-present all uncommitted words |

## Verification
The hardest state to reach is a FIFO that is full of reserved words, which shows `full` and no `valid` at the same time. It is reached by filling to capacity and then acknowledging every word without committing. Acknowledge-then-rewind cases are harder still when the `got` falls in the same cycle as the `commit` or `rollback`. Directed sequences produce both situations. A long pseudo-random sweep over the small default configuration follows; it never raises `commit` and `rollback` together and compares every output in every cycle against an arithmetic pointer model kept in the bench.

// File: rtl/spec_fifo_pkg.sv
package spec_fifo_pkg;

    // Smallest address width whose power of two covers n entries (at least 1).
    function automatic int unsigned addr_bits(input int unsigned n);
        int unsigned b;
        b = 1;
        while ((1 << b) < n) b++;
        return b;
    endfunction

endpackage

// File: rtl/spec_fifo_store.sv
module spec_fifo_store #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spec_rd_ptrs.sv
module spec_rd_ptrs #(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        put,
    input  logic        got,
    input  logic        commit,
    input  logic        rollback,
    output logic [AW:0] wr_ptr,
    output logic [AW:0] rds_ptr,
    output logic [AW:0] rdc_ptr,
    output logic        full,
    output logic        valid,
    output logic        wr_en
);
    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] rds;
        logic [AW:0] rdc;
    } ptr_state_t;

    ptr_state_t st_q, st_d;
    logic       take_put, take_got;
    logic [AW:0] spec_adv;

    assign full  = (st_q.wr[AW] != st_q.rdc[AW]) && (st_q.wr[AW-1:0] == st_q.rdc[AW-1:0]);
    assign valid = (st_q.rds != st_q.wr);

    always_comb begin
        st_d     = st_q;
        take_put = put && !full;
        take_got = got && valid;
        spec_adv = st_q.rds + {{AW{1'b0}}, take_got};
        st_d.wr  = st_q.wr + {{AW{1'b0}}, take_put};
        st_d.rds = spec_adv;
        if (commit) begin
            st_d.rdc = spec_adv;
        end else if (rollback) begin
            st_d.rds = st_q.rdc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_en   = take_put;
    assign wr_ptr  = st_q.wr;
    assign rds_ptr = st_q.rds;
    assign rdc_ptr = st_q.rdc;
endmodule

// File: rtl/spec_level_quant.sv
module spec_level_quant #(
    parameter int AW = 3,
    parameter int W  = 2,
    parameter int OW = 2
) (
    input  logic [AW:0]   cnt,
    output logic [OW-1:0] lvl
);
    generate
        if (W == 0) begin : g_off
            assign lvl = '0;
        end else begin : g_on
            assign lvl = cnt[AW] ? {OW{1'b1}} : cnt[AW-1 -: W];
        end
    endgenerate
endmodule

// File: rtl/spec_rd_fifo.sv
module spec_rd_fifo #(
    parameter int DATA_W    = 8,
    parameter int MIN_DEPTH = 5,
    parameter int FILL_W    = 2,
    parameter int FREE_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            put,
    input  logic [DATA_W-1:0]               din,
    output logic                            full,
    output logic [(FREE_W>0?FREE_W:1)-1:0]  free_lvl,
    input  logic                            got,
    output logic [DATA_W-1:0]               dout,
    output logic                            valid,
    output logic [(FILL_W>0?FILL_W:1)-1:0]  fill_lvl,
    input  logic                            commit,
    input  logic                            rollback
);
    localparam int AW      = spec_fifo_pkg::addr_bits(MIN_DEPTH);
    localparam int DEPTH   = 1 << AW;
    localparam int FILL_OW = (FILL_W > 0) ? FILL_W : 1;
    localparam int FREE_OW = (FREE_W > 0) ? FREE_W : 1;

    logic [AW:0] wr_ptr, rds_ptr, rdc_ptr;
    logic [AW:0] readable, stored, room;
    logic        wr_en;

    spec_rd_ptrs #(.AW(AW)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .put      (put),
        .got      (got),
        .commit   (commit),
        .rollback (rollback),
        .wr_ptr   (wr_ptr),
        .rds_ptr  (rds_ptr),
        .rdc_ptr  (rdc_ptr),
        .full     (full),
        .valid    (valid),
        .wr_en    (wr_en)
    );

    spec_fifo_store #(.DW(DATA_W), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (din),
        .raddr (rds_ptr[AW-1:0]),
        .rdata (dout)
    );

    assign readable = wr_ptr - rds_ptr;
    assign stored   = wr_ptr - rdc_ptr;
    assign room     = (AW+1)'(DEPTH) - stored;

    spec_level_quant #(.AW(AW), .W(FILL_W), .OW(FILL_OW)) u_fill (
        .cnt (readable),
        .lvl (fill_lvl)
    );

    spec_level_quant #(.AW(AW), .W(FREE_W), .OW(FREE_OW)) u_free (
        .cnt (room),
        .lvl (free_lvl)
    );
endmodule

// File: rtl/spec_rd_fifo_chk.sv
module spec_rd_fifo_chk #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          put,
    input logic          got,
    input logic          commit,
    input logic          rollback,
    input logic          full,
    input logic          valid,
    input logic [DW-1:0] dout,
    input logic [AW:0]   wr_ptr,
    input logic [AW:0]   rds_ptr,
    input logic [AW:0]   rdc_ptr
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(1 << AW);

    logic [AW:0] occ, spec_span, spec_nxt;
    assign occ       = wr_ptr - rdc_ptr;
    assign spec_span = rds_ptr - rdc_ptr;
    assign spec_nxt  = rds_ptr + {{AW{1'b0}}, got & valid};

    // R5
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= DEPTH_V);

    // R3
    spec_window_chk: assert property (@(posedge clk) disable iff (rst)
        spec_span <= occ);

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !commit) |=> full);

    // R3
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !put && !rollback) |=> !valid);

    // R6
    commit_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !rollback) |=> (rdc_ptr == $past(spec_nxt)));

    // R7
    rollback_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (rollback && !commit) |=> (rds_ptr == $past(rdc_ptr)));

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !got && !rollback) |=> (valid && $stable(dout)));
endmodule

bind spec_rd_fifo spec_rd_fifo_chk #(.AW(AW), .DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .put      (put),
    .got      (got),
    .commit   (commit),
    .rollback (rollback),
    .full     (full),
    .valid    (valid),
    .dout     (dout),
    .wr_ptr   (wr_ptr),
    .rds_ptr  (rds_ptr),
    .rdc_ptr  (rdc_ptr)
);

// File: tb/sim_spec_rd_fifo.sv
module sim_spec_rd_fifo;
    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       put = 1'b0, got = 1'b0, commit = 1'b0, rollback = 1'b0;
    logic [7:0] din = '0;
    logic       full, valid;
    logic [7:0] dout;
    logic [1:0] fill_lvl, free_lvl;

    int n_cmp = 0;
    int n_bad = 0;

    int         mwr, mrds, mrdc;
    logic [7:0] mmem [8];

    always #(PER/2) clk = ~clk;

    spec_rd_fifo #(.DATA_W(8), .MIN_DEPTH(5), .FILL_W(2), .FREE_W(2)) u0 (
        .clk(clk), .rst(rst), .put(put), .din(din), .full(full), .free_lvl(free_lvl),
        .got(got), .dout(dout), .valid(valid), .fill_lvl(fill_lvl),
        .commit(commit), .rollback(rollback)
    );

    function automatic int quart(input int n);
        return (n >= 8) ? 3 : n / 2;
    endfunction

    task automatic check_all(input string tag);
        int   rd, room;
        logic ef, ev;
        int   efill, efree;
        rd    = (mwr - mrds) & 15;
        room  = 8 - ((mwr - mrdc) & 15);
        ef    = (room == 0);
        ev    = (rd != 0);
        efill = quart(rd);
        efree = quart(room);
        n_cmp++;
        if (full !== ef || valid !== ev || int'(fill_lvl) != efill || int'(free_lvl) != efree
            || (ev && dout !== mmem[mrds % 8])) begin
            n_bad++;
            $display("FAIL %s: full/valid/fill/free/dout = %0b/%0b/%0d/%0d/%h expected %0b/%0b/%0d/%0d/%h",
                     tag, full, valid, fill_lvl, free_lvl, dout, ef, ev, efill, efree,
                     ev ? mmem[mrds % 8] : dout);
        end
    endtask

    task automatic step(input logic p, input logic [7:0] d, input logic g,
                        input logic c, input logic r, input string tag);
        logic ap, ag;
        int   sp;
        put = p; din = d; got = g; commit = c; rollback = r;
        @(posedge clk);
        ap = p && (((mwr - mrdc) & 15) != 8);
        ag = g && (mrds != mwr);
        if (ap) mmem[mwr % 8] = d;
        mwr  = (mwr + int'(ap)) & 15;
        sp   = (mrds + int'(ag)) & 15;
        mrds = sp;
        if (c) mrdc = sp;
        else if (r) mrds = mrdc;
        #1;
        put = 0; got = 0; commit = 0; rollback = 0;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        mwr = 0; mrds = 0; mrdc = 0;
        check_all("R10");
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(PER * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        expect_bit(full, 1'b0, "R10");
        expect_byte({6'd0, free_lvl}, 8'd3, "R10");

        // R1 R4: fill beyond capacity, extra puts ignored
        for (int i = 0; i < 10; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0, "R1 R4");
        expect_bit(full, 1'b1, "R1");
        expect_byte(dout, 8'hA0, "R4");

        // R5: acknowledge all without commit
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, "R5");
        expect_bit(full & ~valid, 1'b1, "R5");
        step(0, 0, 1, 0, 0, "R3");
        step(1, 8'hEE, 0, 0, 0, "R4");

        // R7: plain rollback, then rollback with same-cycle got
        step(0, 0, 0, 0, 1, "R7");
        expect_byte(dout, 8'hA0, "R7");
        step(0, 0, 1, 0, 0, "R7");
        step(0, 0, 1, 0, 0, "R7");
        step(0, 0, 1, 0, 1, "R7");
        expect_byte(dout, 8'hA0, "R7");

        // R6: commit with same-cycle got frees four slots
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, "R6");
        step(0, 0, 1, 1, 0, "R6");
        expect_bit(full, 1'b0, "R6");
        expect_byte({6'd0, free_lvl}, 8'd2, "R6");
        expect_byte(dout, 8'hA4, "R6");

        // R9 R8: refill partially
        step(1, 8'hB0, 0, 0, 0, "R9");
        step(1, 8'hB1, 0, 0, 0, "R8 R9");

        // R2 R8 R9: pseudo-random sweep against the pointer model
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            logic p, g, c, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            p = lfsr[0] | (lfsr[7] & (i[9] == 1'b0));
            g = lfsr[1] | (lfsr[6] & (i[10] == 1'b1));
            c = lfsr[2] & lfsr[3] & lfsr[4];
            r = lfsr[5] & lfsr[8] & lfsr[9] & ~c;
            step(p, lfsr[15:8], g, c, r, "R2 R3 R8 R9");
        end

        // R10: reset from a busy state
        step(1, 8'h55, 0, 0, 0, "R2");
        do_reset();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule